// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a 32-bit virtual address into a physical address after a miss in the translation buffer. It starts from the frame number of the page directory. It fetches the directory entry, then, for a normal 4 KB page, the second-level table entry. Each entry is read one word at a time over a simple request/acknowledge memory port. Before it reports a result, it checks presence and access permission, and it writes the accessed and dirty bits back to memory.

A walk is started with a one-cycle `start` pulse that carries the address, the kind of access (read or write) and the privilege level (user or supervisor). The caller may hand in a directory entry it already holds, so that the directory read is skipped. A directory entry can also map a 4 MB page directly, and then the walk ends after the first level. The walk ends with a one-cycle `done` pulse that carries the physical address and the final copies of both entries, ready for the buffer fill, or with a one-cycle `fault` pulse that carries a reason code.

Top module: `pt_walker`

## Requirements
- R1: The directory entry is read from byte address {dir_frame, va[31:22], 2'b00}.
- R2: For a 4 KB page, the table entry is read from {pde[31:12], va[21:12], 2'b00}, and the physical address is {pte[31:12], va[11:0]}.
- R3: When directory entry bit 7 is 1, the page is 4 MB. The physical address is {pde[31:22], va[21:0]}, no table entry is read, and pte_out is zero.
- R4: If present bit 0 is 0 at either level, the walk ends with fault code 1. No write is issued, and no further read follows.
- R5: If a write meets an entry whose bit 1 (writable) is 0, the code is 2. If a user access meets an entry whose bit 2 (user) is 0, the code is 3. Both levels are checked, a not-present entry outranks both, and code 2 outranks code 3. No write is issued on a fault.
- R6: Every visited entry gets its accessed bit 5 set. The entry is written back to its own address only if that bit was 0.
- R7: On a write access, the final entry (the table entry, or the directory entry of a 4 MB page) also gets its dirty bit 6 set. The directory entry of a 4 KB walk never gets bit 6 set.
- R8: When the start request carries a cached directory entry, no directory read is made. That entry is checked and updated in place of the one in memory.
- R9: At most one memory request is open at any time. mem_req, mem_we, mem_addr and mem_wdata hold steady until mem_ack.
- R10: done and fault are one-cycle pulses and are never high together. pde_out and pte_out show the entries with their updated bits.
- R11: After reset the walker is idle: busy, mem_req, done and fault are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dir_frame | input | 20 | Physical frame number of the page directory |
| start | input | 1 | One-cycle pulse that begins a walk (taken only when idle) |
| start_va | input | 32 | Virtual address to translate |
| start_write | input | 1 | 1 for a write access, 0 for a read access |
| start_user | input | 1 | 1 for a user-mode access |
| start_use_pde | input | 1 | Use start_pde in place of reading the directory |
| start_pde | input | 32 | Cached directory entry |
| mem_req | output | 1 | Memory request open |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Entry value to write |
| mem_ack | input | 1 | Request completed this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Translation result valid |
| fault | output | 1 | Walk ended in a fault |
| fault_code | output | 2 | 0 none, 1 not present, 2 write protection, 3 user protection |
| paddr | output | 32 | Physical address, valid with done |
| large_page | output | 1 | Result is a 4 MB page |
| pde_out | output | 32 | Final directory entry |
| pte_out | output | 32 | Final table entry, zero for a 4 MB page |

## Verification
The bench builds the walker with its default split: a 10-bit directory index, a 10-bit table index and a 12-bit offset. This makes the 32-bit format exact, so it can use hand-computed entry addresses and physical addresses. Its memory model holds every request open for several cycles, so the stability rule of R9 is tested. It also counts the reads and writes of each walk. With these counts, a skipped directory read, a missing write-back or a write after a fault shows up at the ports. The fault cases set several failing bits at once, so the order between the fault codes is visible.

// File: rtl/ptw_pkg.sv
// Shared types for the page table walker: walk states, fault reasons and
// the positions of the entry fields the walker acts on.
package ptw_pkg;
    typedef enum logic [3:0] {
        S_IDLE, S_READ_PDE, S_CHECK_PDE, S_UPDATE_PDE,
        S_READ_PTE, S_CHECK_PTE, S_UPDATE_PTE, S_DONE, S_FAULT
    } walk_state_t;

    typedef enum logic [1:0] {
        FC_NONE        = 2'd0,
        FC_NOT_PRESENT = 2'd1,
        FC_WRITE_PROT  = 2'd2,
        FC_USER_PROT   = 2'd3
    } fault_code_t;

    localparam int unsigned B_PRESENT  = 0;
    localparam int unsigned B_WRITABLE = 1;
    localparam int unsigned B_USER     = 2;
    localparam int unsigned B_ACCESSED = 5;
    localparam int unsigned B_DIRTY    = 6;
    localparam int unsigned B_HUGE     = 7;
endpackage

// File: rtl/ptw_addr_gen.sv
// Address arithmetic of the walk: the entry addresses at both levels and
// the physical address for small and large pages.
// Assumes 4-byte entries, DIR_W + 2 == OFS_W and TBL_W + 2 == OFS_W, so
// that one table fills one page exactly.
module ptw_addr_gen #(
    parameter int DIR_W = 10,
    parameter int TBL_W = 10,
    parameter int OFS_W = 12,
    localparam int AW   = DIR_W + TBL_W + OFS_W,
    localparam int FW   = AW - OFS_W
) (
    input  logic [FW-1:0] dir_frame,
    input  logic [AW-1:0] va,
    input  logic [FW-1:0] pde_frame,
    input  logic [FW-1:0] pte_frame,
    output logic [AW-1:0] pde_addr,
    output logic [AW-1:0] pte_addr,
    output logic [AW-1:0] small_pa,
    output logic [AW-1:0] large_pa
);
    // Index each table with the matching slice of the virtual address.
    always_comb begin
        pde_addr = {dir_frame, va[AW-1 -: DIR_W], 2'b00};
        pte_addr = {pde_frame, va[AW-DIR_W-1 -: TBL_W], 2'b00};
        small_pa = {pte_frame, va[OFS_W-1:0]};
        large_pa = {pde_frame[FW-1 -: DIR_W], va[AW-DIR_W-1:0]};
    end
endmodule

// File: rtl/ptw_entry_check.sv
// Checks one entry for presence and permission, and forms the updated
// entry with the accessed bit (and the dirty bit if asked) set.
// Priority: not present, then write protection, then user protection.
module ptw_entry_check
    import ptw_pkg::*;
#(
    parameter int EW = 32
) (
    input  logic [EW-1:0] entry,
    input  logic          is_write,
    input  logic          is_user,
    input  logic          may_dirty,
    output fault_code_t   code,
    output logic [EW-1:0] entry_upd,
    output logic          need_wb
);
    // Choose the fault with the highest priority.
    always_comb begin
        if (!entry[B_PRESENT])                    code = FC_NOT_PRESENT;
        else if (is_write && !entry[B_WRITABLE])  code = FC_WRITE_PROT;
        else if (is_user && !entry[B_USER])       code = FC_USER_PROT;
        else                                      code = FC_NONE;
    end

    // Form the entry to write back, and flag it if any bit changes.
    always_comb begin
        entry_upd = entry;
        entry_upd[B_ACCESSED] = 1'b1;
        if (may_dirty && is_write) entry_upd[B_DIRTY] = 1'b1;
        need_wb = (entry_upd != entry);
    end
endmodule

// File: rtl/pt_walker.sv
// Two-level page table walker. It takes one walk at a time from a start
// pulse and keeps at most one word request open on the memory port. It
// ends with a done pulse (result on paddr/pde_out/pte_out) or a fault pulse.
// Assumes the memory answers every request with a single mem_ack cycle.
module pt_walker
    import ptw_pkg::*;
#(
    parameter int DIR_W = 10,
    parameter int TBL_W = 10,
    parameter int OFS_W = 12,
    localparam int AW   = DIR_W + TBL_W + OFS_W,
    localparam int FW   = AW - OFS_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [FW-1:0] dir_frame,
    input  logic          start,
    input  logic [AW-1:0] start_va,
    input  logic          start_write,
    input  logic          start_user,
    input  logic          start_use_pde,
    input  logic [AW-1:0] start_pde,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [AW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [AW-1:0] mem_rdata,
    output logic          busy,
    output logic          done,
    output logic          fault,
    output logic [1:0]    fault_code,
    output logic [AW-1:0] paddr,
    output logic          large_page,
    output logic [AW-1:0] pde_out,
    output logic [AW-1:0] pte_out
);
    walk_state_t   state;
    logic [AW-1:0] va_q, pde_q, pte_q;
    logic          write_q, user_q;
    fault_code_t   fault_q;

    logic [AW-1:0] pde_addr, pte_addr, small_pa, large_pa;
    logic [AW-1:0] pde_upd, pte_upd;
    logic          pde_wb, pte_wb;
    fault_code_t   pde_code, pte_code;

    ptw_addr_gen #(.DIR_W(DIR_W), .TBL_W(TBL_W), .OFS_W(OFS_W)) u_addr (
        .dir_frame (dir_frame),
        .va        (va_q),
        .pde_frame (pde_q[AW-1:OFS_W]),
        .pte_frame (pte_q[AW-1:OFS_W]),
        .pde_addr  (pde_addr),
        .pte_addr  (pte_addr),
        .small_pa  (small_pa),
        .large_pa  (large_pa)
    );

    ptw_entry_check #(.EW(AW)) u_chk_pde (
        .entry     (pde_q),
        .is_write  (write_q),
        .is_user   (user_q),
        .may_dirty (pde_q[B_HUGE]),
        .code      (pde_code),
        .entry_upd (pde_upd),
        .need_wb   (pde_wb)
    );

    ptw_entry_check #(.EW(AW)) u_chk_pte (
        .entry     (pte_q),
        .is_write  (write_q),
        .is_user   (user_q),
        .may_dirty (1'b1),
        .code      (pte_code),
        .entry_upd (pte_upd),
        .need_wb   (pte_wb)
    );

    // Drive the memory port from the state: one request per access state.
    always_comb begin
        mem_req   = (state == S_READ_PDE) || (state == S_UPDATE_PDE) ||
                    (state == S_READ_PTE) || (state == S_UPDATE_PTE);
        mem_we    = (state == S_UPDATE_PDE) || (state == S_UPDATE_PTE);
        mem_addr  = ((state == S_READ_PDE) || (state == S_UPDATE_PDE)) ? pde_addr : pte_addr;
        mem_wdata = (state == S_UPDATE_PDE) ? pde_q : pte_q;
    end

    // Drive the result outputs from the registered walk state.
    always_comb begin
        busy       = (state != S_IDLE);
        done       = (state == S_DONE);
        fault      = (state == S_FAULT);
        fault_code = fault_q;
        large_page = pde_q[B_HUGE];
        paddr      = pde_q[B_HUGE] ? large_pa : small_pa;
        pde_out    = pde_q;
        pte_out    = pte_q;
    end

    // Walk sequencer: capture the request, fetch and check the entries, write back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            va_q    <= '0;
            pde_q   <= '0;
            pte_q   <= '0;
            write_q <= 1'b0;
            user_q  <= 1'b0;
            fault_q <= FC_NONE;
        end else begin
            case (state)
                S_IDLE: if (start) begin
                    va_q    <= start_va;
                    write_q <= start_write;
                    user_q  <= start_user;
                    pte_q   <= '0;
                    fault_q <= FC_NONE;
                    pde_q   <= start_use_pde ? start_pde : '0;
                    state   <= start_use_pde ? S_CHECK_PDE : S_READ_PDE;
                end
                S_READ_PDE: if (mem_ack) begin
                    pde_q <= mem_rdata;
                    state <= S_CHECK_PDE;
                end
                S_CHECK_PDE: begin
                    if (pde_code != FC_NONE) begin
                        fault_q <= pde_code;
                        state   <= S_FAULT;
                    end else begin
                        pde_q <= pde_upd;
                        if (pde_wb)              state <= S_UPDATE_PDE;
                        else if (pde_q[B_HUGE])  state <= S_DONE;
                        else                     state <= S_READ_PTE;
                    end
                end
                S_UPDATE_PDE: if (mem_ack)
                    state <= pde_q[B_HUGE] ? S_DONE : S_READ_PTE;
                S_READ_PTE: if (mem_ack) begin
                    pte_q <= mem_rdata;
                    state <= S_CHECK_PTE;
                end
                S_CHECK_PTE: begin
                    if (pte_code != FC_NONE) begin
                        fault_q <= pte_code;
                        state   <= S_FAULT;
                    end else begin
                        pte_q <= pte_upd;
                        state <= pte_wb ? S_UPDATE_PTE : S_DONE;
                    end
                end
                S_UPDATE_PTE: if (mem_ack) state <= S_DONE;
                S_DONE, S_FAULT: state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // R9: an open request keeps its command and data until acknowledged.
    a_r9_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    // R10: the two end-of-walk pulses exclude each other.
    a_r10_done_xor_fault: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault));

    // R6: a write-back always carries a present entry with accessed set.
    a_r6_wb_accessed: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> mem_wdata[B_ACCESSED] && mem_wdata[B_PRESENT]);

    // R4: a fault carries a reason and follows no write in the cycle before.
    a_r4_fault_reason: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (fault_code != FC_NONE) && !$past(mem_we));

    // R3: a large-page walk never reaches the second level.
    a_r3_no_table_read: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_READ_PTE) |-> !large_page);

    // R10: a done pulse lasts one cycle.
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/tb_pt_walker.sv
// Directed bench: a word memory model that stalls each request, and one
// task per scenario.
module tb_pt_walker;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] dir_frame = 20'h00010;
    logic        start = 1'b0;
    logic [31:0] start_va = '0;
    logic        start_write = 1'b0, start_user = 1'b0, start_use_pde = 1'b0;
    logic [31:0] start_pde = '0;
    logic        mem_req, mem_we, mem_ack = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic        busy, done, fault, large_page;
    logic [1:0]  fault_code;
    logic [31:0] paddr, pde_out, pte_out;

    pt_walker dut (
        .clk(clk), .rst_n(rst_n), .dir_frame(dir_frame), .start(start),
        .start_va(start_va), .start_write(start_write), .start_user(start_user),
        .start_use_pde(start_use_pde), .start_pde(start_pde),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .busy(busy), .done(done),
        .fault(fault), .fault_code(fault_code), .paddr(paddr), .large_page(large_page),
        .pde_out(pde_out), .pte_out(pte_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0, bad = 0;
    logic [31:0] mem [logic [31:0]];
    int rd_cnt, wr_cnt, wait_cnt = 0, hold_err = 0;
    logic [31:0] first_rd_addr, held_addr, held_wdata;
    logic        res_done, res_fault, res_large;
    logic [1:0]  res_code;
    logic [31:0] res_pa, res_pde, res_pte;

    // Memory model: each request waits two cycles, then is acked for one.
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
            wait_cnt = 0;
        end else if (mem_req) begin
            if (wait_cnt == 0) begin
                held_addr = mem_addr;
                held_wdata = mem_wdata;
            end else if (mem_addr != held_addr || mem_wdata != held_wdata) begin
                hold_err++;
            end
            if (wait_cnt == 2) begin
                if (mem_we) begin
                    mem[mem_addr] = mem_wdata;
                    wr_cnt++;
                end else begin
                    mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
                    if (rd_cnt == 0) first_rd_addr = mem_addr;
                    rd_cnt++;
                end
                mem_ack = 1'b1;
            end else begin
                wait_cnt++;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Start a walk and capture the end pulse.
    task automatic walk(input logic [31:0] va, input bit wr, input bit usr,
                        input bit use_pde, input logic [31:0] cpde);
        rd_cnt = 0; wr_cnt = 0; hold_err = 0; first_rd_addr = '0;
        @(negedge clk);
        start = 1'b1; start_va = va; start_write = wr; start_user = usr;
        start_use_pde = use_pde; start_pde = cpde;
        @(negedge clk);
        start = 1'b0;
        res_done = 1'b0; res_fault = 1'b0;
        for (int i = 0; i < 200; i++) begin
            if (done || fault) begin
                res_done = done; res_fault = fault; res_code = fault_code;
                res_pa = paddr; res_pde = pde_out; res_pte = pte_out; res_large = large_page;
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
        check(!done && !fault, "R10 end pulse lasts one cycle", {30'b0, done, fault}, 32'h0);
        check(hold_err == 0, "R9 request held until ack", hold_err, 0);
    endtask

    task automatic t_reset;
        check(!busy && !mem_req && !done && !fault, "R11 idle after reset",
              {28'b0, busy, mem_req, done, fault}, 32'h0);
    endtask

    task automatic t_read_sets_accessed;
        mem.delete();
        mem[32'h00010004] = 32'h00020007;
        mem[32'h0002000C] = 32'h00555007;
        walk(32'h00403ABC, 0, 0, 0, 0);
        check(res_done && !res_fault, "R2 4KB read completes", {30'b0, res_done, res_fault}, 32'h2);
        check(first_rd_addr == 32'h00010004, "R1 directory entry address", first_rd_addr, 32'h00010004);
        check(res_pa == 32'h00555ABC, "R2 physical address", res_pa, 32'h00555ABC);
        check(mem[32'h00010004] == 32'h00020027, "R6 PDE accessed written back", mem[32'h00010004], 32'h00020027);
        check(mem[32'h0002000C] == 32'h00555027, "R6 PTE accessed written back", mem[32'h0002000C], 32'h00555027);
        check(rd_cnt == 2 && wr_cnt == 2, "R6 two reads two writes", rd_cnt * 16 + wr_cnt, 32'h22);
        check(res_pte == 32'h00555027 && res_pde == 32'h00020027, "R10 reported entries updated", res_pte, 32'h00555027);
    endtask

    task automatic t_write_sets_dirty;
        mem.delete();
        mem[32'h00010004] = 32'h00020007;
        mem[32'h0002000C] = 32'h00555007;
        walk(32'h00403ABC, 1, 0, 0, 0);
        check(mem[32'h0002000C] == 32'h00555067, "R7 PTE dirty and accessed", mem[32'h0002000C], 32'h00555067);
        check(mem[32'h00010004] == 32'h00020027, "R7 PDE no dirty on 4KB walk", mem[32'h00010004], 32'h00020027);
        // Second write: only the dirty bit is missing at the table level.
        mem[32'h0002000C] = 32'h00555027;
        walk(32'h00403ABC, 1, 0, 0, 0);
        check(wr_cnt == 1 && mem[32'h0002000C] == 32'h00555067, "R7 single dirty write-back", wr_cnt, 1);
        // Third write: nothing changes, so nothing is written.
        walk(32'h00403ABC, 1, 0, 0, 0);
        check(res_done && wr_cnt == 0 && rd_cnt == 2, "R6 no write when bits already set", wr_cnt, 0);
    endtask

    task automatic t_not_present;
        mem.delete();
        mem[32'h00010004] = 32'hFFFFFFFE;
        walk(32'h00403ABC, 1, 1, 0, 0);
        check(res_fault && res_code == 2'd1, "R4 PDE not present code", {30'b0, res_code}, 1);
        check(rd_cnt == 1 && wr_cnt == 0, "R4 stops after PDE, no write", rd_cnt * 16 + wr_cnt, 32'h10);
        mem[32'h00010004] = 32'h00020027;
        mem[32'h0002000C] = 32'h00555006;
        walk(32'h00403ABC, 0, 0, 0, 0);
        check(res_fault && res_code == 2'd1, "R4 PTE not present code", {30'b0, res_code}, 1);
        check(wr_cnt == 0 && mem[32'h0002000C] == 32'h00555006, "R4 PTE untouched", mem[32'h0002000C], 32'h00555006);
    endtask

    task automatic t_protection;
        mem.delete();
        mem[32'h00010004] = 32'h00020027;
        mem[32'h0002000C] = 32'h00555025;
        walk(32'h00403ABC, 1, 0, 0, 0);
        check(res_fault && res_code == 2'd2, "R5 write to read-only PTE", {30'b0, res_code}, 2);
        check(wr_cnt == 0, "R5 no write-back on fault", wr_cnt, 0);
        mem[32'h00010004] = 32'h00020023;
        walk(32'h00403ABC, 0, 1, 0, 0);
        check(res_fault && res_code == 2'd3 && rd_cnt == 1, "R5 user access to supervisor PDE", {30'b0, res_code}, 3);
        mem[32'h00010004] = 32'h00020027;
        mem[32'h0002000C] = 32'h00555021;
        walk(32'h00403ABC, 1, 1, 0, 0);
        check(res_fault && res_code == 2'd2, "R5 write outranks user", {30'b0, res_code}, 2);
    endtask

    task automatic t_large_page;
        mem.delete();
        mem[32'h0001000C] = 32'h1C000087;
        walk(32'h00C12345, 1, 0, 0, 0);
        check(res_done && res_large, "R3 large page done", {30'b0, res_done, res_large}, 3);
        check(res_pa == 32'h1C012345, "R3 large physical address", res_pa, 32'h1C012345);
        check(rd_cnt == 1 && wr_cnt == 1, "R3 one read one write", rd_cnt * 16 + wr_cnt, 32'h11);
        check(mem[32'h0001000C] == 32'h1C0000E7, "R7 dirty set in large PDE", mem[32'h0001000C], 32'h1C0000E7);
        check(res_pte == 32'h0, "R3 pte_out zero", res_pte, 0);
    endtask

    task automatic t_cached_pde;
        mem.delete();
        mem[32'h00010004] = 32'h00000000;
        mem[32'h0002000C] = 32'h00555027;
        walk(32'h00403ABC, 0, 1, 1, 32'h00020027);
        check(res_done && res_pa == 32'h00555ABC, "R8 cached PDE translation", res_pa, 32'h00555ABC);
        check(rd_cnt == 1 && first_rd_addr == 32'h0002000C, "R8 directory read skipped", first_rd_addr, 32'h0002000C);
        walk(32'h00403ABC, 0, 0, 1, 32'h00020007);
        check(mem[32'h00010004] == 32'h00020027 && wr_cnt == 1, "R8 cached PDE accessed written back",
              mem[32'h00010004], 32'h00020027);
    endtask

    // Watchdog: a hung run counts as a failed check and still reports.
    initial begin
        #(CLK_PERIOD * 100000);
        total++; bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_sets_accessed();
        t_write_sets_dirty();
        t_not_present();
        t_protection();
        t_large_page();
        t_cached_pde();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule